// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes that an 8-bit microcontroller core shows on its external memory bus. One is an active-high address-latch pulse, which tells external logic when to capture the low address byte. The other is an active-low program-fetch read strobe. Both are built from the oscillator clock and from a machine-cycle phase count that the core supplies. A machine cycle lasts 12 oscillator clocks and is made of two 6-clock halves.

The address-latch pulse runs once in every half cycle. The pulse of the second half is dropped when the core flags an access to external data memory. A control bit written by software can silence the pulse. While the pulse is silenced, the output is released, so it floats high, except during move-data or move-code instructions. When the core executes from external program memory, the control bit has no effect. In that mode the fetch strobe runs once in every half cycle, and both of its assertions are dropped in a machine cycle that accesses external data.

All outputs are registered. Each output therefore reflects the inputs that were present on the previous clock edge.

Top module: `xbs_strobe_gen`

## Requirements
- R1: While `rst` is high, on every clock `ale` becomes 0, `ale_oe` becomes 1, `psen_n` becomes 1 and the disable bit clears to 0.
- R2: With the bit clear and no external data access, `ale` is 1 exactly in the cycle after a phase whose position within its half (phase mod 6) is below `ALE_W` (default 2). This gives two pulses per 12-clock machine cycle.
- R3: When `xdata_cycle` is 1 with a phase of 6 to 11, `ale` is 0 in the next cycle. A pulse in phases 0 to 5 is not affected.
- R4: A clock with `reg_wr_en`=1 and `reg_wr_addr`=`REG_ADDR` (default 0x8E) loads `reg_wr_data` bit 0 into the disable bit. Outputs follow the new value one clock later. A write to any other address leaves the bit unchanged.
- R5: With the bit set, `ext_exec`=0 and `movx_movc`=0, the next cycle has `ale_oe`=0 and `ale`=1, meaning the pin is released and pulled high.
- R6: With the bit set, `ext_exec`=0 and `movx_movc`=1, `ale` and `ale_oe` follow the same pattern as in R2 and R3.
- R7: With `ext_exec`=1, the disable bit has no effect: `ale_oe`=1 and `ale` follows R2 and R3.
- R8: With `ext_exec`=1 and `xdata_cycle`=0, `psen_n` is 0 in the cycle after a phase whose position within its half is from `PSEN_START` up to `PSEN_START+PSEN_W-1` (default 3 to 5). Otherwise it is 1.
- R9: `psen_n` is 1 in the cycle after any clock with `xdata_cycle`=1 or with `ext_exec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_phase | input | 4 | Oscillator clock index within the machine cycle, 0 to 11 |
| xdata_cycle | input | 1 | The current machine cycle accesses external data memory |
| movx_movc | input | 1 | A move-data or move-code instruction is executing |
| ext_exec | input | 1 | The core executes from external program memory |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data; bit 0 is the disable bit |
| ale | output | 1 | Address latch pulse, active high |
| ale_oe | output | 1 | Address latch pin drive enable; 0 releases the pin |
| psen_n | output | 1 | Program fetch read strobe, active low |

## Verification
The hardest case to reach is the interaction of the disable bit with the other inputs. That requires a write to the disable bit at the exact register address, followed by machine cycles in which the execution mode, the instruction flag and the data-access flag each change. Random writes land on the control address about half the time, so the bit toggles often and wrong-address writes are also exercised. The bench redraws the mode and instruction flags at each machine-cycle boundary and now and then in mid-cycle, so the second-half skip is reached in every combination of bit and mode. A directed sequence first checks the pulse train after reset, and then checks that a write to a neighbouring address leaves the pulses running.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int HALF_CLKS = 6;
  localparam int CYCLE_CLKS = 2 * HALF_CLKS;
  localparam int PHASE_W = $clog2(CYCLE_CLKS);

  typedef struct packed {
    logic second_half;
    logic ale_win;
    logic psen_win;
  } xbs_window_t;
endpackage

// File: rtl/xbs_phase_decode.sv
module xbs_phase_decode
  import xbs_pkg::*;
#(
  parameter int ALE_W      = 2,
  parameter int PSEN_START = 3,
  parameter int PSEN_W     = 3
) (
  input  logic [PHASE_W-1:0] phase,
  output xbs_window_t        win
);
  localparam logic [PHASE_W-1:0] HALF     = PHASE_W'(HALF_CLKS);
  localparam logic [PHASE_W-1:0] ALE_END  = PHASE_W'(ALE_W);
  localparam logic [PHASE_W-1:0] PS_FIRST = PHASE_W'(PSEN_START);
  localparam logic [PHASE_W-1:0] PS_END   = PHASE_W'(PSEN_START + PSEN_W);

  logic [PHASE_W-1:0] pos;

  always_comb begin
    win.second_half = (phase >= HALF);
    pos             = win.second_half ? (phase - HALF) : phase;
    win.ale_win     = (pos < ALE_END);
    win.psen_win    = (pos >= PS_FIRST) && (pos < PS_END);
  end
endmodule

// File: rtl/xbs_ctrl_reg.sv
module xbs_ctrl_reg #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h8E,
  parameter int          DIS_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dis_q
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)
      dis_q <= 1'b0;
    else if (wr_en && (wr_addr == MATCH))
      dis_q <= wr_data[DIS_BIT];
  end
endmodule

// File: rtl/xbs_strobe_core.sv
module xbs_strobe_core
  import xbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  xbs_window_t win,
  input  logic        xdata_cycle,
  input  logic        movx_movc,
  input  logic        ext_exec,
  input  logic        dis,
  output logic        ale,
  output logic        ale_oe,
  output logic        psen_n
);
  logic drive_nx, ale_nx, psen_nx, skip_ale;

  always_comb begin
    drive_nx = !dis || ext_exec || movx_movc;
    skip_ale = xdata_cycle && win.second_half;
    ale_nx   = drive_nx ? (win.ale_win && !skip_ale) : 1'b1;
    psen_nx  = !(ext_exec && !xdata_cycle && win.psen_win);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      ale_oe <= 1'b1;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_nx;
      ale_oe <= drive_nx;
      psen_n <= psen_nx;
    end
  end
endmodule

// File: rtl/xbs_strobe_gen.sv
module xbs_strobe_gen
  import xbs_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] REG_ADDR   = 8'h8E,
  parameter int         DIS_BIT    = 0,
  parameter int         ALE_W      = 2,
  parameter int         PSEN_START = 3,
  parameter int         PSEN_W     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] cyc_phase,
  input  logic               xdata_cycle,
  input  logic               movx_movc,
  input  logic               ext_exec,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [DATA_W-1:0]  reg_wr_data,
  output logic               ale,
  output logic               ale_oe,
  output logic               psen_n
);
  xbs_window_t win;
  logic        dis_q;

  xbs_phase_decode #(
    .ALE_W(ALE_W), .PSEN_START(PSEN_START), .PSEN_W(PSEN_W)
  ) u_decode (
    .phase(cyc_phase),
    .win  (win)
  );

  xbs_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .DIS_BIT(DIS_BIT)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data),
    .dis_q  (dis_q)
  );

  xbs_strobe_core u_core (
    .clk        (clk),
    .rst        (rst),
    .win        (win),
    .xdata_cycle(xdata_cycle),
    .movx_movc  (movx_movc),
    .ext_exec   (ext_exec),
    .dis        (dis_q),
    .ale        (ale),
    .ale_oe     (ale_oe),
    .psen_n     (psen_n)
  );
endmodule

// File: rtl/xbs_strobe_checker.sv
module xbs_strobe_checker
  import xbs_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] cyc_phase,
  input logic               xdata_cycle,
  input logic               movx_movc,
  input logic               ext_exec,
  input logic               dis_q,
  input logic               ale,
  input logic               ale_oe,
  input logic               psen_n
);
  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(HALF_CLKS);

  // R5: released pin when silenced outside move instructions
  p_released_r5: assert property (@(posedge clk) disable iff (rst)
    (dis_q && !ext_exec && !movx_movc) |=> (ale && !ale_oe));

  // R7: external execution always drives the latch pin
  p_ext_drive_r7: assert property (@(posedge clk) disable iff (rst)
    ext_exec |=> ale_oe);

  // R3: second-half pulse dropped on external data cycles
  p_skip_half_r3: assert property (@(posedge clk) disable iff (rst)
    (xdata_cycle && (cyc_phase >= HALF)) |=> !(ale && ale_oe));

  // R9: fetch strobe idle on data cycles or internal execution
  p_psen_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (xdata_cycle || !ext_exec) |=> psen_n);

  // R8: a driven latch pulse never coincides with a fetch strobe
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(ale && ale_oe && !psen_n));
endmodule

bind xbs_strobe_gen xbs_strobe_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cyc_phase  (cyc_phase),
  .xdata_cycle(xdata_cycle),
  .movx_movc  (movx_movc),
  .ext_exec   (ext_exec),
  .dis_q      (dis_q),
  .ale        (ale),
  .ale_oe     (ale_oe),
  .psen_n     (psen_n)
);

// File: tb/xbs_strobe_gen_bench.sv
module xbs_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cyc_phase = '0;
  logic       xdata_cycle = 1'b0, movx_movc = 1'b0, ext_exec = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_addr = '0, reg_wr_data = '0;
  logic       ale, ale_oe, psen_n;

  int  n_run = 0, n_fail = 0;
  bit  model_dis = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  xbs_strobe_gen u_xbs_strobe_gen (
    .clk(clk), .rst(rst), .cyc_phase(cyc_phase), .xdata_cycle(xdata_cycle),
    .movx_movc(movx_movc), .ext_exec(ext_exec), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n)
  );

  function automatic int pos_of(input int ph);
    return (ph >= 6) ? ph - 6 : ph;
  endfunction

  function automatic bit exp_oe(input bit d, input bit ex, input bit mv);
    return !d || ex || mv;
  endfunction

  function automatic bit exp_ale(input int ph, input bit xd, input bit d,
                                 input bit ex, input bit mv);
    if (!exp_oe(d, ex, mv)) return 1'b1;
    if (xd && ph >= 6) return 1'b0;
    return pos_of(ph) < 2;
  endfunction

  function automatic bit exp_psen(input int ph, input bit xd, input bit ex);
    return !(ex && !xd && pos_of(ph) >= 3 && pos_of(ph) <= 5);
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input int ph, input bit xd, input bit mv, input bit ex,
                      input bit we, input logic [7:0] wa, input logic [7:0] wd);
    bit ea, eo, ep;
    string ta, tp;
    cyc_phase = 4'(ph); xdata_cycle = xd; movx_movc = mv; ext_exec = ex;
    reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
    ea = exp_ale(ph, xd, model_dis, ex, mv);
    eo = exp_oe(model_dis, ex, mv);
    ep = exp_psen(ph, xd, ex);
    if (!eo) ta = "R5";
    else if (xd && ph >= 6) ta = "R3";
    else if (model_dis && ex) ta = "R7";
    else if (model_dis) ta = "R6";
    else ta = "R2";
    tp = (ex && !xd) ? "R8" : "R9";
    @(posedge clk);
    if (we && wa == 8'h8E) model_dis = wd[0];
    @(negedge clk);
    check(ta, "ale", ale, ea);
    check(ta, "ale_oe", ale_oe, eo);
    check(tp, "psen_n", psen_n, ep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit xd, mv, ex;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "ale", ale, 1'b0);
    check("R1", "ale_oe", ale_oe, 1'b1);
    check("R1", "psen_n", psen_n, 1'b1);
    rst = 1'b0;
    // R2: plain pulse train, two machine cycles
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 12; p++) step(p, 0, 0, 0, 0, 8'h00, 8'h00);
    // R4: write to a neighbouring address is ignored
    step(0, 0, 0, 0, 1, 8'h8F, 8'hFF);
    for (int p = 1; p < 12; p++) step(p, 0, 0, 0, 0, 8'h00, 8'h00);
    // R4/R5: set the bit, then observe release
    step(0, 0, 0, 0, 1, 8'h8E, 8'h01);
    for (int p = 1; p < 12; p++) step(p, 0, 0, 0, 0, 8'h00, 8'h00);
    // R6/R3: move instruction with a data access while silenced
    for (int p = 0; p < 12; p++) step(p, 1, 1, 0, 0, 8'h00, 8'h00);
    // R7/R8: external execution overrides the bit
    for (int p = 0; p < 12; p++) step(p, 0, 0, 1, 0, 8'h00, 8'h00);
    // R9: external execution with data access
    for (int p = 0; p < 12; p++) step(p, 1, 0, 1, 0, 8'h00, 8'h00);
    // random phase of the run
    xd = 0; mv = 0; ex = 0;
    for (int c = 0; c < 400; c++) begin
      for (int p = 0; p < 12; p++) begin
        bit we;
        logic [7:0] wa;
        if (p == 0 || ($urandom % 8) == 0) begin
          mv = $urandom % 2; ex = $urandom % 2;
        end
        if (p == 0) xd = ($urandom % 3) == 0;
        we = ($urandom % 16) == 0;
        wa = ($urandom % 2) ? 8'h8E : 8'($urandom);
        step(p, xd, mv, ex, we, wa, 8'($urandom));
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule